// File: doc/BRIEF.md
# Redirection-Table Interrupt Destination Router

This block turns an interrupt request number into a vector delivered to one processor. It holds a table of redirection entries, one per interrupt source. Each entry is a pair of 32-bit words loaded through a write port. When an interrupt request arrives, the router reads the matching entry and extracts the 8-bit vector. It then uses the entry's destination mode to pick exactly one target port. One clock after the request, it raises that port's delivery strobe and reports a status code.

A second port keeps a registry of which target identifiers are present. Each registration request is answered with its own status code one clock later. In physical mode, the entry names a single target identifier. In logical mode, the entry carries an 8-bit mask, and the lowest-numbered present target whose mask bit is set wins. The entry's delivery-mode field is not interpreted. The router has no arbitration between targets and no end-of-interrupt handling.

Status encoding on both status outputs: 0 = success, 1 = out of range, 2 = not found, 3 = already present.

Top module: `irq_dest_router`

## Requirements
- R1: An interrupt request whose index is at or above NUM_ENTRIES produces status 1 (out of range), and no delivery strobe is raised.
- R2: Every interrupt request produces exactly one `irq_done` pulse with a status, on the clock edge that follows the request. `irq_done` stays low in cycles without a request.
- R3: A successful delivery raises exactly one bit of `dlv_strobe`, and `dlv_vector` then equals bits 7:0 of the entry's low word. When no strobe is raised, `dlv_vector` is zero and the status is not 0.
- R4: Bit 11 of the low word selects the destination mode: 0 is physical and 1 is logical. Bits 10:8 of the low word (the delivery mode) have no effect on the routing.
- R5: In physical mode, the target identifier is bits 27:24 of the high word. If that target is registered, strobe bit [identifier] is raised with status 0. The high word's bits 31:28 have no effect.
- R6: In physical mode, an identifier at or above NUM_TGT, or an identifier that is not registered, gives status 2 (not found) and no strobe.
- R7: In logical mode, the mask is bits 31:24 of the high word, and mask bit n selects target n. Delivery goes only to the lowest-numbered selected target that is registered. Selected but unregistered targets are skipped. If no target qualifies, the result is status 2.
- R8: A registration request answers one clock later on `reg_done`/`reg_status`. An identifier at or above NUM_TGT gives 1. An identifier already registered gives 3. Otherwise the result is 0 and the target becomes present.
- R9: Reset empties the registry and clears all outputs. Table entries keep their contents across reset.
- R10: An interrupt request issued in the same cycle as a registration routes against the registry as it stood before that registration.
- R11: A table write with an index below NUM_ENTRIES stores both words, and later requests for that index use them. The last entry (index NUM_ENTRIES-1) is reachable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Redirection entry write enable |
| tbl_idx | input | IDX_W | Entry index to write |
| tbl_lo | input | 32 | Low entry word (vector, mode, delivery mode) |
| tbl_hi | input | 32 | High entry word (destination) |
| irq_valid | input | 1 | Interrupt request strobe |
| irq_index | input | IDX_W | Interrupt request number |
| reg_valid | input | 1 | Target registration strobe |
| reg_id | input | TID_W | Target identifier to register |
| irq_done | output | 1 | Routing result valid |
| irq_status | output | 2 | Routing status |
| dlv_strobe | output | NUM_TGT | Per-target delivery strobe |
| dlv_vector | output | 8 | Delivered vector |
| reg_done | output | 1 | Registration result valid |
| reg_status | output | 2 | Registration status |

## Verification
The hardest case is logical delivery where the lowest mask bits point at unregistered targets. In that case the choice depends jointly on the mask and the registry. The stimulus therefore registers a sparse set of targets, {2, 5, 7}. It then fires masks whose lower set bits miss that set, so the router must skip to a higher target. Registration racing with a request in the same cycle is also set up on purpose, to show which state the router uses. A reset pulse is then issued mid-run to show that the registry empties while the table persists.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int WORD_W      = 32;
  localparam int VEC_W       = 8;
  localparam int MODE_BIT    = 11;
  localparam int PHYS_LSB    = 24;
  localparam int PHYS_W      = 4;
  localparam int LMASK_LSB   = 24;
  localparam int LMASK_W     = 8;

  typedef enum logic [1:0] {
    ST_OK        = 2'd0,
    ST_RANGE     = 2'd1,
    ST_ABSENT    = 2'd2,
    ST_DUPLICATE = 2'd3
  } route_status_e;

  typedef struct packed {
    logic [WORD_W-1:0] hi;
    logic [WORD_W-1:0] lo;
  } redir_entry_t;

endpackage

// File: rtl/redir_table.sv
module redir_table
  import irq_router_pkg::*;
#(
  parameter int NUM_ENTRIES = 24,
  parameter int ADDR_W      = $clog2(NUM_ENTRIES),
  parameter int IDX_W       = ADDR_W + 1
) (
  input  logic         clk,
  input  logic         wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  redir_entry_t wr_entry,
  input  logic [IDX_W-1:0] rd_idx,
  output redir_entry_t rd_entry,
  output logic         rd_in_range
);

  localparam logic [IDX_W-1:0] LIMIT = IDX_W'(NUM_ENTRIES);

  redir_entry_t mem [NUM_ENTRIES];

  logic wr_ok;
  assign wr_ok = wr_en && (wr_idx < LIMIT);

  // Plain write port, no reset: maps to distributed RAM.
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_idx[ADDR_W-1:0]] <= wr_entry;
  end

  assign rd_in_range = rd_idx < LIMIT;

  always_comb begin
    rd_entry = '0;
    if (rd_in_range) rd_entry = mem[rd_idx[ADDR_W-1:0]];
  end

endmodule

// File: rtl/target_registry.sv
module target_registry
  import irq_router_pkg::*;
#(
  parameter int NUM_TGT = 8,
  parameter int SEL_W   = $clog2(NUM_TGT),
  parameter int TID_W   = SEL_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [TID_W-1:0]   req_id,
  output logic [NUM_TGT-1:0] present,
  output logic               resp_valid,
  output logic [1:0]         resp_status
);

  localparam logic [TID_W-1:0] LIMIT = TID_W'(NUM_TGT);

  logic       in_range;
  logic       already;
  logic [1:0] next_status;

  assign in_range = req_id < LIMIT;
  assign already  = in_range && present[req_id[SEL_W-1:0]];

  always_comb begin
    if (!in_range)    next_status = ST_RANGE;
    else if (already) next_status = ST_DUPLICATE;
    else              next_status = ST_OK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      present     <= '0;
      resp_valid  <= 1'b0;
      resp_status <= ST_OK;
    end else begin
      resp_valid  <= req_valid;
      resp_status <= req_valid ? next_status : ST_OK;
      if (req_valid && in_range && !already)
        present[req_id[SEL_W-1:0]] <= 1'b1;
    end
  end

endmodule

// File: rtl/dest_decoder.sv
module dest_decoder
  import irq_router_pkg::*;
#(
  parameter int NUM_TGT = 8
) (
  input  redir_entry_t       entry,
  input  logic [NUM_TGT-1:0] present,
  output logic [NUM_TGT-1:0] target,
  output logic [VEC_W-1:0]   vector,
  output logic               found
);

  logic [PHYS_W-1:0]  phys_id;
  logic [31:0]        phys_id_w;
  logic               logical;
  logic [NUM_TGT-1:0] phys_sel;
  logic [NUM_TGT-1:0] lmask;
  logic [NUM_TGT-1:0] cand;

  assign phys_id   = entry.hi[PHYS_LSB +: PHYS_W];
  assign phys_id_w = 32'(phys_id);
  assign logical   = entry.lo[MODE_BIT];
  assign vector    = entry.lo[VEC_W-1:0];

  for (genvar n = 0; n < NUM_TGT; n++) begin : g_tgt
    assign phys_sel[n] = (phys_id_w == 32'(n));
    if (n < LMASK_W) begin : g_masked
      assign lmask[n] = entry.hi[LMASK_LSB + n];
    end else begin : g_unmasked
      assign lmask[n] = 1'b0;
    end
  end

  assign cand   = (logical ? lmask : phys_sel) & present;
  // Isolate the lowest set bit: ascending-identifier priority.
  assign target = cand & (~cand + NUM_TGT'(1));
  assign found  = |cand;

endmodule

// File: rtl/irq_dest_router.sv
module irq_dest_router
  import irq_router_pkg::*;
#(
  parameter int  NUM_ENTRIES = 24,
  parameter int  NUM_TGT     = 8,
  localparam int IDX_W       = $clog2(NUM_ENTRIES) + 1,
  localparam int TID_W       = $clog2(NUM_TGT) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tbl_we,
  input  logic [IDX_W-1:0]   tbl_idx,
  input  logic [31:0]        tbl_lo,
  input  logic [31:0]        tbl_hi,
  input  logic               irq_valid,
  input  logic [IDX_W-1:0]   irq_index,
  input  logic               reg_valid,
  input  logic [TID_W-1:0]   reg_id,
  output logic               irq_done,
  output logic [1:0]         irq_status,
  output logic [NUM_TGT-1:0] dlv_strobe,
  output logic [7:0]         dlv_vector,
  output logic               reg_done,
  output logic [1:0]         reg_status
);

  redir_entry_t       wr_entry;
  redir_entry_t       rd_entry;
  logic               rd_in_range;
  logic [NUM_TGT-1:0] present;
  logic [NUM_TGT-1:0] target;
  logic [VEC_W-1:0]   vector;
  logic               found;

  assign wr_entry.lo = tbl_lo;
  assign wr_entry.hi = tbl_hi;

  redir_table #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .ADDR_W      (IDX_W - 1),
    .IDX_W       (IDX_W)
  ) u_table (
    .clk         (clk),
    .wr_en       (tbl_we),
    .wr_idx      (tbl_idx),
    .wr_entry    (wr_entry),
    .rd_idx      (irq_index),
    .rd_entry    (rd_entry),
    .rd_in_range (rd_in_range)
  );

  target_registry #(
    .NUM_TGT     (NUM_TGT),
    .SEL_W       (TID_W - 1),
    .TID_W       (TID_W)
  ) u_registry (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (reg_valid),
    .req_id      (reg_id),
    .present     (present),
    .resp_valid  (reg_done),
    .resp_status (reg_status)
  );

  dest_decoder #(
    .NUM_TGT (NUM_TGT)
  ) u_decode (
    .entry   (rd_entry),
    .present (present),
    .target  (target),
    .vector  (vector),
    .found   (found)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_done   <= 1'b0;
      irq_status <= ST_OK;
      dlv_strobe <= '0;
      dlv_vector <= '0;
    end else begin
      irq_done   <= irq_valid;
      irq_status <= ST_OK;
      dlv_strobe <= '0;
      dlv_vector <= '0;
      if (irq_valid) begin
        if (!rd_in_range) begin
          irq_status <= ST_RANGE;
        end else if (!found) begin
          irq_status <= ST_ABSENT;
        end else begin
          dlv_strobe <= target;
          dlv_vector <= vector;
        end
      end
    end
  end

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int  NUM_ENTRIES = 24,
  parameter int  NUM_TGT     = 8,
  localparam int IDX_W       = $clog2(NUM_ENTRIES) + 1,
  localparam int TID_W       = $clog2(NUM_TGT) + 1
) (
  input logic               clk,
  input logic               rst,
  input logic               irq_valid,
  input logic [IDX_W-1:0]   irq_index,
  input logic               reg_valid,
  input logic [TID_W-1:0]   reg_id,
  input logic               irq_done,
  input logic [1:0]         irq_status,
  input logic [NUM_TGT-1:0] dlv_strobe,
  input logic [7:0]         dlv_vector,
  input logic               reg_done,
  input logic [1:0]         reg_status
);

  // R1
  index_range_chk: assert property (@(posedge clk) disable iff (rst)
    irq_valid && (irq_index >= IDX_W'(NUM_ENTRIES)) |=>
      (irq_status == ST_RANGE) && (dlv_strobe == '0));

  // R2
  done_follows_chk: assert property (@(posedge clk) disable iff (rst)
    irq_valid |=> irq_done);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_valid |=> !irq_done && (dlv_strobe == '0));

  // R3
  single_target_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dlv_strobe));

  // R3
  vector_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (dlv_strobe == '0) |-> (dlv_vector == '0));

  // R3
  status_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    irq_done |-> ((irq_status == ST_OK) == (dlv_strobe != '0)));

  // R8
  reg_answer_chk: assert property (@(posedge clk) disable iff (rst)
    reg_valid |=> reg_done);

  // R8
  reg_range_chk: assert property (@(posedge clk) disable iff (rst)
    reg_valid && (reg_id >= TID_W'(NUM_TGT)) |=> (reg_status == ST_RANGE));

endmodule

bind irq_dest_router irq_router_chk #(
  .NUM_ENTRIES (NUM_ENTRIES),
  .NUM_TGT     (NUM_TGT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .irq_valid  (irq_valid),
  .irq_index  (irq_index),
  .reg_valid  (reg_valid),
  .reg_id     (reg_id),
  .irq_done   (irq_done),
  .irq_status (irq_status),
  .dlv_strobe (dlv_strobe),
  .dlv_vector (dlv_vector),
  .reg_done   (reg_done),
  .reg_status (reg_status)
);

// File: tb/test_irq_dest_router.sv
`timescale 1ns/1ps
module test_irq_dest_router;

  localparam int NE = 24;
  localparam int NT = 8;
  localparam int IW = $clog2(NE) + 1;
  localparam int TW = $clog2(NT) + 1;

  localparam logic [1:0] OK = 2'd0, RNG = 2'd1, ABS = 2'd2, DUP = 2'd3;
  localparam logic [31:0] LOGIC_MODE = 32'h0000_0800;

  logic          clk = 1'b0;
  logic          rst;
  logic          tbl_we;
  logic [IW-1:0] tbl_idx;
  logic [31:0]   tbl_lo, tbl_hi;
  logic          irq_valid;
  logic [IW-1:0] irq_index;
  logic          reg_valid;
  logic [TW-1:0] reg_id;
  logic          irq_done;
  logic [1:0]    irq_status;
  logic [NT-1:0] dlv_strobe;
  logic [7:0]    dlv_vector;
  logic          reg_done;
  logic [1:0]    reg_status;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  irq_dest_router #(.NUM_ENTRIES(NE), .NUM_TGT(NT)) i_irq_dest_router (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_lo(tbl_lo), .tbl_hi(tbl_hi), .irq_valid(irq_valid),
    .irq_index(irq_index), .reg_valid(reg_valid), .reg_id(reg_id),
    .irq_done(irq_done), .irq_status(irq_status), .dlv_strobe(dlv_strobe),
    .dlv_vector(dlv_vector), .reg_done(reg_done), .reg_status(reg_status)
  );

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    tbl_we    = 1'b0;
    irq_valid = 1'b0;
    reg_valid = 1'b0;
  endtask

  task automatic put_entry(int idx, logic [31:0] lo, logic [31:0] hi);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = IW'(idx); tbl_lo = lo; tbl_hi = hi;
    tick();
  endtask

  task automatic enroll(string tag, int id, logic [1:0] exp);
    @(negedge clk);
    reg_valid = 1'b1; reg_id = TW'(id);
    tick();
    chk({tag, " done"}, int'(reg_done), 1);
    chk({tag, " status"}, int'(reg_status), int'(exp));
  endtask

  task automatic route(string tag, int idx, logic [1:0] st, int strobe, int vec);
    @(negedge clk);
    irq_valid = 1'b1; irq_index = IW'(idx);
    tick();
    chk({tag, " done"}, int'(irq_done), 1);
    chk({tag, " status"}, int'(irq_status), int'(st));
    chk({tag, " strobe"}, int'(dlv_strobe), strobe);
    chk({tag, " vector"}, int'(dlv_vector), vec);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // R9: reset state and empty registry
  task automatic t_reset();
    do_reset();
    #1;
    chk("R9 irq_done after reset", int'(irq_done), 0);
    chk("R9 strobe after reset", int'(dlv_strobe), 0);
    chk("R9 reg_done after reset", int'(reg_done), 0);
    put_entry(0, 32'h0000_0041, 32'h0200_0000);
    route("R9 empty registry", 0, ABS, 0, 0);
  endtask

  // R8: registration outcomes
  task automatic t_enroll();
    enroll("R8 new id 2", 2, OK);
    enroll("R8 repeat id 2", 2, DUP);
    enroll("R8 id 8 out of range", 8, RNG);
    enroll("R8 id 15 out of range", 15, RNG);
    enroll("R8 new id 5", 5, OK);
    enroll("R8 new id 7", 7, OK);
  endtask

  // R5 R6: physical routing; registry holds {2,5,7}
  task automatic t_physical();
    route("R5 phys target 2", 0, OK, 'h04, 'h41);
    put_entry(1, 32'h0000_0042, 32'h0300_0000);
    route("R6 phys unregistered 3", 1, ABS, 0, 0);
    put_entry(2, 32'h0000_0043, 32'h0900_0000);
    route("R6 phys id 9 beyond count", 2, ABS, 0, 0);
    put_entry(3, 32'h0000_0044, 32'hF500_0000);
    route("R5 phys upper bits ignored", 3, OK, 'h20, 'h44);
  endtask

  // R7: logical routing
  task automatic t_logical();
    put_entry(4, LOGIC_MODE | 32'h51, 32'h0A00_0000);
    route("R7 mask hits only absent", 4, ABS, 0, 0);
    put_entry(5, LOGIC_MODE | 32'h52, 32'h2C00_0000);
    route("R7 lowest of 2,3,5", 5, OK, 'h04, 'h52);
    put_entry(6, LOGIC_MODE | 32'h53, 32'hA800_0000);
    route("R7 skip absent 3 to 5", 6, OK, 'h20, 'h53);
    put_entry(7, LOGIC_MODE | 32'h54, 32'h8000_0000);
    route("R7 single bit 7", 7, OK, 'h80, 'h54);
    put_entry(8, LOGIC_MODE | 32'h55, 32'h0000_0000);
    route("R7 empty mask", 8, ABS, 0, 0);
  endtask

  // R4: delivery-mode bits ignored in both modes
  task automatic t_delmode();
    put_entry(9, 32'h0000_0761, 32'h0700_0000);
    route("R4 phys with delmode 7", 9, OK, 'h80, 'h61);
    put_entry(10, 32'h0000_0F62, 32'h0600_0000);
    route("R4 logical with delmode 7", 10, OK, 'h04, 'h62);
  endtask

  // R1 R11: index bounds
  task automatic t_range();
    route("R1 index 24", NE, RNG, 0, 0);
    route("R1 index max", (1 << IW) - 1, RNG, 0, 0);
    put_entry(NE - 1, 32'h0000_0099, 32'h0500_0000);
    route("R11 last entry", NE - 1, OK, 'h20, 'h99);
    @(negedge clk);
    tick();
    chk("R2 idle cycle no done", int'(irq_done), 0);
  endtask

  // R10: same-cycle registration and request
  task automatic t_race();
    put_entry(11, 32'h0000_0070, 32'h0400_0000);
    @(negedge clk);
    reg_valid = 1'b1; reg_id = TW'(4);
    irq_valid = 1'b1; irq_index = IW'(11);
    tick();
    chk("R10 race status", int'(irq_status), int'(ABS));
    chk("R10 race strobe", int'(dlv_strobe), 0);
    chk("R10 race reg status", int'(reg_status), int'(OK));
    route("R10 after registration", 11, OK, 'h10, 'h70);
  endtask

  // R9: reset clears registry, keeps table
  task automatic t_reset_clears();
    do_reset();
    route("R9 registry cleared", 0, ABS, 0, 0);
    enroll("R9 reenroll 2", 2, OK);
    route("R9 table kept", 0, OK, 'h04, 'h41);
  endtask

  initial begin
    rst = 1'b1; tbl_we = 1'b0; tbl_idx = '0; tbl_lo = '0; tbl_hi = '0;
    irq_valid = 1'b0; irq_index = '0; reg_valid = 1'b0; reg_id = '0;
    t_reset();
    t_enroll();
    t_physical();
    t_logical();
    t_delmode();
    t_range();
    t_race();
    t_reset_clears();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule